// File: doc/BRIEF.md
# RSSI Slope Jump Detector

This block watches a stream of received-signal-strength samples. It flags a sudden change in level: a rise, a fall, or either one. Each new sample is compared with the sample stored a programmable number of sample periods before it. The block therefore responds to how fast the level changes, not to the level itself. A slow drift that stays under the threshold within the window never raises an event.

The host arms the block once the incoming signal has been qualified. The arrival of the wanted signal would otherwise look like a jump. An event can set a sticky interrupt flag, which the host clears by writing one. An event can also emit a one-cycle pulse that restarts the receiver's acquisition. After a restart pulse the block empties its history and stays silent until it is armed again.

Top module: `rssi_slope_detector`

## Requirements
- R1: Rises and falls are separate events, gated by `rise_en` and `fall_en`. Both may be enabled at once. At most one of `jump_up` and `jump_dn` is high in any cycle.
- R2: An event needs a level difference of at least `thresh`. A difference of `thresh` fires, and a difference of `thresh-1` does not.
- R3: The difference is taken against the sample accepted `lag_m1+1` valid samples earlier, so lag_m1 = 0 means the previous sample. A ramp that changes by less than `thresh` over that window raises no event.
- R4: When `restart_en` is high, every event also drives `rx_restart` high for exactly one cycle, in the same cycle as the event flag. When `restart_en` is low, `rx_restart` stays low.
- R5: When `irq_en` is high, an event sets `irq`. `irq` stays set until a cycle with `irq_clr` high and no new event. If an event and `irq_clr` arrive in the same cycle, the set wins.
- R6: While `arm` is low, samples are ignored, no flag is raised, and the stored history count returns to zero.
- R7: After arming, no event fires until `lag_m1+1` samples have been stored.
- R8: After a restart pulse, the history is emptied. No event fires until `arm` has gone low and high again and the history has refilled.
- R9: `jump_up` and `jump_dn` are one-cycle pulses, registered on the clock edge that accepts the sample. All outputs are low after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_vld | input | 1 | Sample strobe |
| smp | input | 8 | Unsigned signal-strength sample |
| thresh | input | 8 | Minimum level change for an event |
| lag_m1 | input | 4 | Lookback length minus one, in samples |
| rise_en | input | 1 | Enable rise events |
| fall_en | input | 1 | Enable fall events |
| arm | input | 1 | Detection armed (level) |
| restart_en | input | 1 | Emit restart pulse on events |
| irq_en | input | 1 | Set interrupt on events |
| irq_clr | input | 1 | Write-one-to-clear for the interrupt |
| jump_up | output | 1 | Rise event pulse |
| jump_dn | output | 1 | Fall event pulse |
| irq | output | 1 | Sticky interrupt flag |
| rx_restart | output | 1 | Receiver restart pulse |

## Verification
Some properties are checked by assertions on every cycle:
- the two event flags are never high together;
- each flag only follows a cycle in which its enable was set;
- the restart pulse lasts a single cycle and leaves the history count at zero;
- the interrupt holds until a clear arrives.

Other behaviour shows only in the bench's scenarios, where a reference model predicts each sample's outcome:
- the exact threshold boundary;
- the choice of the lagged sample;
- the silence of a slow ramp;
- the fill-up suppression after arming;
- the need to re-arm after a restart.

// File: rtl/rssi_slope_detector.sv
module rssi_slope_detector #(
  parameter int W     = 8,
  parameter int DEPTH = 16,
  localparam int LW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          smp_vld,
  input  logic [W-1:0]  smp,
  input  logic [W-1:0]  thresh,
  input  logic [LW-1:0] lag_m1,
  input  logic          rise_en,
  input  logic          fall_en,
  input  logic          arm,
  input  logic          restart_en,
  input  logic          irq_en,
  input  logic          irq_clr,
  output logic          jump_up,
  output logic          jump_dn,
  output logic          irq,
  output logic          rx_restart
);

  logic [W-1:0]  hist [DEPTH];
  logic [CW-1:0] fill;
  logic          blocked;

  wire          active = arm && !blocked;
  wire [W-1:0]  old    = hist[lag_m1];
  wire          full   = fill > CW'(lag_m1);
  wire          take   = smp_vld && active;
  wire          rise   = (smp > old) && ((smp - old) >= thresh);
  wire          fall   = (old > smp) && ((old - smp) >= thresh);
  wire          hit_up = take && full && rise_en && rise;
  wire          hit_dn = take && full && fall_en && fall;
  wire          hit    = hit_up || hit_dn;
  wire          do_rst = hit && restart_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) hist[i] <= '0;
    end else if (take) begin
      hist[0] <= smp;
      for (int i = 1; i < DEPTH; i++) hist[i] <= hist[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill       <= '0;
      blocked    <= 1'b0;
      jump_up    <= 1'b0;
      jump_dn    <= 1'b0;
      rx_restart <= 1'b0;
      irq        <= 1'b0;
    end else begin
      jump_up    <= hit_up;
      jump_dn    <= hit_dn;
      rx_restart <= do_rst;
      if (!arm)        blocked <= 1'b0;
      else if (do_rst) blocked <= 1'b1;
      if (!active || do_rst)                  fill <= '0;
      else if (smp_vld && fill != CW'(DEPTH)) fill <= fill + 1'b1;
      if (hit && irq_en) irq <= 1'b1;
      else if (irq_clr)  irq <= 1'b0;
    end
  end

  logic past_ok;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;

  AST_ONE_DIRECTION: assert property (@(posedge clk) disable iff (!rst_n)
    !(jump_up && jump_dn)); // R1
  AST_UP_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && jump_up) |-> $past(rise_en)); // R1
  AST_DN_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && jump_dn) |-> $past(fall_en)); // R1
  AST_RESTART_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_restart |=> !rx_restart); // R4
  AST_RESTART_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && rx_restart) |-> ($past(restart_en) && (jump_up || jump_dn))); // R4
  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(irq) && !$past(irq_clr)) |-> irq); // R5
  AST_UNARMED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && !$past(arm)) |-> (!jump_up && !jump_dn)); // R6
  AST_FLUSH_ON_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    rx_restart |-> (fill == '0)); // R8

endmodule

// File: tb/sim_rssi_slope_detector.sv
module sim_rssi_slope_detector;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic smp_vld = 1'b0;
  logic [7:0] smp = '0;
  logic [7:0] thresh = 8'd10;
  logic [3:0] lag_m1 = 4'd3;
  logic rise_en = 1'b0, fall_en = 1'b0, arm = 1'b0;
  logic restart_en = 1'b0, irq_en = 1'b0, irq_clr = 1'b0;
  logic jump_up, jump_dn, irq, rx_restart;

  always #10 clk = ~clk;

  rssi_slope_detector u0 (.*);

  int total = 0, bad = 0;
  logic [3:0] exp_q [$];
  string tag_q [$];

  logic [7:0] m_hist [16];
  int m_fill = 0;
  bit m_blocked = 0, m_irq = 0;

  task automatic chk(string tag, logic [3:0] act, logic [3:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: {up,dn,rst,irq} actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic set_arm(bit v);
    arm = v;
    if (!v) begin m_fill = 0; m_blocked = 0; end
    @(negedge clk);
  endtask

  task automatic send(logic [7:0] s, string tag);
    bit act_ok, full, up, dn, rs;
    logic [7:0] old;
    act_ok = arm && !m_blocked;
    old  = m_hist[lag_m1];
    full = m_fill >= int'(lag_m1) + 1;
    up = act_ok && full && rise_en && s > old && (s - old) >= thresh;
    dn = act_ok && full && fall_en && old > s && (old - s) >= thresh;
    rs = (up || dn) && restart_en;
    if ((up || dn) && irq_en) m_irq = 1;
    if (act_ok) begin
      for (int i = 15; i > 0; i--) m_hist[i] = m_hist[i-1];
      m_hist[0] = s;
      if (m_fill < 16) m_fill++;
    end
    if (rs) begin m_fill = 0; m_blocked = 1; end
    exp_q.push_back({up, dn, rs, m_irq});
    tag_q.push_back(tag);
    smp = s; smp_vld = 1'b1;
    @(negedge clk);
    smp_vld = 1'b0;
  endtask

  logic vld_seen = 1'b0;
  always @(posedge clk) vld_seen <= smp_vld;

  always @(negedge clk) begin
    if (vld_seen && exp_q.size() > 0)
      chk(tag_q.pop_front(), {jump_up, jump_dn, rx_restart, irq}, exp_q.pop_front());
  end

  initial begin
    #2_000_000;
    bad++; total++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) m_hist[i] = '0;
    repeat (3) @(negedge clk);
    chk("R9 reset", {jump_up, jump_dn, rx_restart, irq}, 4'b0000);
    rst_n = 1'b1;
    @(negedge clk);

    // R6: unarmed samples ignored
    rise_en = 1; fall_en = 1; irq_en = 0;
    send(8'd10, "R6"); send(8'd200, "R6"); send(8'd0, "R6");

    // R7: fill-up suppression, lag 4
    set_arm(1);
    send(8'd100, "R7"); send(8'd100, "R7"); send(8'd100, "R7");
    send(8'd180, "R7");
    send(8'd115, "R2");
    // R3: slow ramp, 2 per sample, 8 per window
    for (int i = 0; i < 8; i++) send(8'(120 + 2 * i), "R3");
    // R2 boundary: flat then +9 (none), then flat then +10
    for (int i = 0; i < 4; i++) send(8'd140, "R2");
    send(8'd149, "R2");
    for (int i = 0; i < 4; i++) send(8'd150, "R2");
    send(8'd160, "R2");
    // R1: fall, then rise disabled
    for (int i = 0; i < 4; i++) send(8'd160, "R1");
    send(8'd130, "R1");
    rise_en = 0;
    for (int i = 0; i < 4; i++) send(8'd50, "R1");
    send(8'd90, "R1");
    // R3: lag 1 compares with the previous sample
    rise_en = 1; lag_m1 = 4'd0;
    send(8'd60, "R3"); send(8'd75, "R3"); send(8'd70, "R3");
    // R5: interrupt set and held, then cleared
    irq_en = 1;
    send(8'd100, "R5"); send(8'd100, "R5"); send(8'd101, "R5");
    irq_clr = 1; @(negedge clk); irq_clr = 0; m_irq = 0;
    send(8'd102, "R5");
    // R5: set wins over a simultaneous clear
    irq_clr = 1;
    send(8'd150, "R5");
    irq_clr = 0;
    send(8'd150, "R5");
    // R4/R8: restart, then blocked until re-armed
    restart_en = 1; lag_m1 = 4'd1;
    send(8'd150, "R4"); send(8'd200, "R4");
    send(8'd100, "R8"); send(8'd250, "R8"); send(8'd10, "R8");
    set_arm(0); set_arm(1);
    send(8'd10, "R8"); send(8'd10, "R8"); send(8'd90, "R8");
    // R4: restart disabled gives no pulse
    set_arm(0); set_arm(1); restart_en = 0;
    send(8'd90, "R4"); send(8'd90, "R4"); send(8'd20, "R4");
    send(8'd20, "R4");
    // R6: disarm mid-stream clears history
    set_arm(0);
    send(8'd250, "R6");
    set_arm(1);
    send(8'd0, "R6"); send(8'd255, "R6");

    repeat (4) @(negedge clk);
    total++;
    if (exp_q.size() != 0) begin
      bad++;
      $display("FAIL R9: pending actual=%0d expected=0", exp_q.size());
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule